// File: doc/BRIEF.md
# Interrupt Cause Register Bank

This block gathers up to 32 hardware event lines into a cause register. Each bit stays pending until the host clears it. A host-side register port lets software read the pending causes and clear them. Software can also raise causes itself, mask or unmask individual bits, and pick, bit by bit, whether reading the cause clears it. The single level interrupt output is high whenever any pending bit is unmasked.

The mask changes only through two dedicated write locations. One of them sets mask bits and the other clears them, so no read-modify-write of the mask is needed. Each cause bit is either write-one-to-clear or clear-on-read. A clear-on-read configuration can leave out a single bit, such as bit 27 with the value 0xF7FFFFFF. That bit then survives every read until it is explicitly cleared.

The host port is a valid/ready command channel with a valid/ready response channel for reads. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. A read returns its data on the response channel in the cycle after it is taken. That response is held, with its data unchanged, until `rsp_ready` is high. While a response waits, `cmd_ready` is low, so at most one read is outstanding. Writes produce no response.

Top module: `irq_cause_bank`

## Requirements
- R1: After reset all cause bits are 0, all mask bits are 1, all clear-mode bits are 0 (write-one-to-clear), `irq` is low and no response is pending.
- R2: A 1 on any bit of `hw_evt` at a clock edge sets that cause bit. The bit stays set until the host clears it.
- R3: A write to address 0 (cause) clears every cause bit written as 1 and leaves bits written as 0 unchanged. Writing back a value just read therefore clears exactly the bits that were seen.
- R4: A write to address 1 (raise) sets every cause bit written as 1. A read of address 1 returns 0.
- R5: A write to address 2 sets every mask bit written as 1. A write to address 3 clears every mask bit written as 1. A read of address 6 returns the mask.
- R6: Address 4 holds the clear-mode bits, which can be read and written. A read of address 0 returns the cause and then clears the cause bits whose clear-mode bit is 1; the other bits stay pending.
- R7: A read of address 5 returns cause AND NOT mask. It then clears the bits of that returned value whose clear-mode bit is 1; masked bits are not touched.
- R8: `irq` is high exactly when cause AND NOT mask is non-zero.
- R9: When an event and a clear (write-one-to-clear or clear-on-read) hit the same bit in the same cycle, the event wins and the bit stays set.
- R10: Read data appears with `rsp_valid` in the cycle after the read is taken. It is held stable while `rsp_ready` is low, and during that time `cmd_ready` is low. Writes give no response, and a read of address 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_evt | input | 32 | Hardware event lines, one per cause bit |
| cmd_valid | input | 1 | Host command valid |
| cmd_ready | output | 1 | Host command accepted this cycle when high with `cmd_valid` |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 3 | Register address |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Host accepts the read response |
| rsp_data | output | 32 | Read response data |
| irq | output | 1 | Level interrupt, OR of unmasked pending bits |

## Verification
Events are injected on sparse patterns that mix masked and unmasked bits. This separates the raw cause view from the masked view, and shows that a read of the masked view leaves masked bits alone. The clear-mode value with only bit 27 excluded shows that a single bit can outlive reads while its neighbours clear. Events are fired in the same cycle as a write clear and as a clearing read, which checks the event-wins rule on both clear paths. A stalled response checks that the read data holds and that new commands are refused.

// File: rtl/irq_cause_bank_pkg.sv
`timescale 1ns/1ps
package irq_cause_bank_pkg;

  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    SEL_CAUSE    = 3'd0,
    SEL_RAISE    = 3'd1,
    SEL_MASK_ON  = 3'd2,
    SEL_MASK_OFF = 3'd3,
    SEL_CLRMODE  = 3'd4,
    SEL_PENDING  = 3'd5,
    SEL_MASKVAL  = 3'd6,
    SEL_SPARE    = 3'd7
  } reg_sel_e;

  // One-cycle strobes decoded from an accepted host command
  typedef struct packed {
    logic rd_cause;
    logic rd_pending;
    logic wr_cause;
    logic wr_raise;
    logic wr_mask_on;
    logic wr_mask_off;
    logic wr_clrmode;
  } host_op_t;

endpackage

// File: rtl/icb_host_port.sv
`timescale 1ns/1ps
module icb_host_port
  import irq_cause_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmd_valid,
  output logic                  cmd_ready,
  input  logic                  cmd_write,
  input  logic [ADDR_W-1:0]     cmd_addr,
  output logic                  rsp_valid,
  input  logic                  rsp_ready,
  output logic [WIDTH-1:0]      rsp_data,
  input  logic [WIDTH-1:0]      cause_q,
  input  logic [WIDTH-1:0]      mask_q,
  input  logic [WIDTH-1:0]      clrmode_q,
  output host_op_t              op
);

  logic             accept;
  logic [WIDTH-1:0] rd_mux;
  reg_sel_e         sel;

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign accept    = cmd_valid && cmd_ready;
  assign sel       = reg_sel_e'(cmd_addr);

  always_comb begin
    op = '0;
    if (accept) begin
      if (cmd_write) begin
        op.wr_cause    = (sel == SEL_CAUSE);
        op.wr_raise    = (sel == SEL_RAISE);
        op.wr_mask_on  = (sel == SEL_MASK_ON);
        op.wr_mask_off = (sel == SEL_MASK_OFF);
        op.wr_clrmode  = (sel == SEL_CLRMODE);
      end else begin
        op.rd_cause    = (sel == SEL_CAUSE);
        op.rd_pending  = (sel == SEL_PENDING);
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_CAUSE:   rd_mux = cause_q;
      SEL_PENDING: rd_mux = cause_q & ~mask_q;
      SEL_CLRMODE: rd_mux = clrmode_q;
      SEL_MASKVAL: rd_mux = mask_q;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (rsp_valid && rsp_ready) rsp_valid <= 1'b0;
      if (accept && !cmd_write) begin
        rsp_valid <= 1'b1;
        rsp_data  <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/icb_ctrl_regs.sv
`timescale 1ns/1ps
module icb_ctrl_regs
  import irq_cause_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  host_op_t         op,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] mask_q,
  output logic [WIDTH-1:0] clrmode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q    <= '1;
      clrmode_q <= '0;
    end else begin
      if (op.wr_mask_on)  mask_q <= mask_q | wdata;
      if (op.wr_mask_off) mask_q <= mask_q & ~wdata;
      if (op.wr_clrmode)  clrmode_q <= wdata;
    end
  end

endmodule

// File: rtl/icb_cause_store.sv
`timescale 1ns/1ps
module icb_cause_store
  import irq_cause_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hw_evt,
  input  host_op_t         op,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] mask_q,
  input  logic [WIDTH-1:0] clrmode_q,
  output logic [WIDTH-1:0] cause_q
);

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic set_b;
    logic clr_b;

    assign set_b = hw_evt[b] | (op.wr_raise & wdata[b]);
    assign clr_b = (op.wr_cause & wdata[b])
                 | (op.rd_cause & clrmode_q[b])
                 | (op.rd_pending & clrmode_q[b] & ~mask_q[b]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cause_q[b] <= 1'b0;
      else if (set_b) cause_q[b] <= 1'b1;
      else if (clr_b) cause_q[b] <= 1'b0;
    end
  end

endmodule

// File: rtl/irq_cause_bank.sv
`timescale 1ns/1ps
module irq_cause_bank
  import irq_cause_bank_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WIDTH-1:0]  hw_evt,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [WIDTH-1:0]  cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WIDTH-1:0]  rsp_data,
  output logic              irq
);

  host_op_t         op;
  logic [WIDTH-1:0] cause_q;
  logic [WIDTH-1:0] mask_q;
  logic [WIDTH-1:0] clrmode_q;

  icb_host_port #(.WIDTH(WIDTH)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .cause_q   (cause_q),
    .mask_q    (mask_q),
    .clrmode_q (clrmode_q),
    .op        (op)
  );

  icb_ctrl_regs #(.WIDTH(WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .op        (op),
    .wdata     (cmd_wdata),
    .mask_q    (mask_q),
    .clrmode_q (clrmode_q)
  );

  icb_cause_store #(.WIDTH(WIDTH)) u_cause (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_evt    (hw_evt),
    .op        (op),
    .wdata     (cmd_wdata),
    .mask_q    (mask_q),
    .clrmode_q (clrmode_q),
    .cause_q   (cause_q)
  );

  assign irq = |(cause_q & ~mask_q);

endmodule

// File: rtl/irq_cause_bank_chk.sv
`timescale 1ns/1ps
module irq_cause_bank_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] hw_evt,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic             cmd_write,
  input logic [2:0]       cmd_addr,
  input logic [WIDTH-1:0] cmd_wdata,
  input logic             rsp_valid,
  input logic             rsp_ready,
  input logic [WIDTH-1:0] rsp_data,
  input logic             irq,
  input logic [WIDTH-1:0] cause_q,
  input logic [WIDTH-1:0] mask_q
);

  logic wr_go;
  assign wr_go = cmd_valid && cmd_ready && cmd_write;

  // R9: an event always leaves its bit set, whatever clear ran alongside
  assert_evt_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_evt) |=> ((cause_q & $past(hw_evt)) == $past(hw_evt)));

  // R4: raise write sets the written bits
  assert_raise_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cmd_addr == 3'd1) |=> ((cause_q & $past(cmd_wdata)) == $past(cmd_wdata)));

  // R5: mask-on and mask-off writes
  assert_mask_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cmd_addr == 3'd2) |=> ((mask_q & $past(cmd_wdata)) == $past(cmd_wdata)));

  assert_mask_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && cmd_addr == 3'd3) |=> ((mask_q & $past(cmd_wdata)) == '0));

  // R8: fully masked bank never interrupts
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !irq);

  // R10: a stalled response holds and blocks new commands
  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_stall_blocks_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready);

  // R10: a write never produces a response
  assert_write_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !rsp_valid) |=> !rsp_valid);

endmodule

bind irq_cause_bank irq_cause_bank_chk #(.WIDTH(WIDTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .hw_evt    (hw_evt),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_write (cmd_write),
  .cmd_addr  (cmd_addr),
  .cmd_wdata (cmd_wdata),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_data  (rsp_data),
  .irq       (irq),
  .cause_q   (cause_q),
  .mask_q    (mask_q)
);

// File: tb/test_irq_cause_bank.sv
`timescale 1ns/1ps
module test_irq_cause_bank;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] hw_evt;
  logic         cmd_valid, cmd_ready, cmd_write;
  logic [2:0]   cmd_addr;
  logic [W-1:0] cmd_wdata;
  logic         rsp_valid, rsp_ready;
  logic [W-1:0] rsp_data;
  logic         irq;

  always #2.5 clk = ~clk;

  irq_cause_bank #(.WIDTH(W)) i_irq_cause_bank (
    .clk(clk), .rst_n(rst_n), .hw_evt(hw_evt),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .irq(irq)
  );

  int n_tests = 0;
  int n_fail  = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  // bench model, built from the requirements
  logic [W-1:0] m_cause, m_mask, m_cor;

  task automatic check(input bit ok, input string tag,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit wr, input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    #1;
    while (!cmd_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic reg_write(input logic [2:0] a, input logic [W-1:0] d);
    bus(1'b1, a, d);
    case (a)
      3'd0: m_cause &= ~d;
      3'd1: m_cause |= d;
      3'd2: m_mask  |= d;
      3'd3: m_mask  &= ~d;
      3'd4: m_cor   = d;
      default: ;
    endcase
  endtask

  task automatic reg_read(input logic [2:0] a, input string tag);
    logic [W-1:0] e;
    case (a)
      3'd0: e = m_cause;
      3'd4: e = m_cor;
      3'd5: e = m_cause & ~m_mask;
      3'd6: e = m_mask;
      default: e = '0;
    endcase
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (a == 3'd0) m_cause &= ~m_cor;
    if (a == 3'd5) m_cause &= ~(m_cor & ~m_mask);
    bus(1'b0, a, '0);
  endtask

  task automatic pulse_evt(input logic [W-1:0] v);
    @(negedge clk); hw_evt = v;
    @(negedge clk); hw_evt = '0;
    m_cause |= v;
  endtask

  task automatic check_irq(input string tag);
    logic e;
    e = |(m_cause & ~m_mask);
    check(irq == e, tag, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, e});
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk); #1;
      if (rst_n && rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) check(1'b0, "R10 unexpected response", rsp_data, '0);
        else begin
          logic [W-1:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(rsp_data == e, t, rsp_data, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    rst_n = 1'b0; hw_evt = '0; cmd_valid = 1'b0; cmd_write = 1'b0;
    cmd_addr = '0; cmd_wdata = '0; rsp_ready = 1'b1;
    m_cause = '0; m_mask = '1; m_cor = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;

    // R1 reset state
    check(cmd_ready && !rsp_valid, "R1 port idle", {30'd0, cmd_ready, rsp_valid}, 32'h2);
    check_irq("R1 irq low");
    reg_read(3'd6, "R1 mask all ones");
    reg_read(3'd0, "R1 cause zero");
    reg_read(3'd4, "R1 clear-mode zero");
    drain();

    // R2 events latch and persist through W1C-mode reads
    pulse_evt(32'h0000_0015);
    reg_read(3'd0, "R2 cause latched");
    reg_read(3'd0, "R2 cause persists");
    drain();
    check_irq("R8 masked bits silent");

    // R5 unmask, R8 irq, R7 masked view
    reg_write(3'd3, 32'h0000_0005);
    reg_read(3'd6, "R5 mask after clear");
    drain();
    check_irq("R8 irq on unmasked pending");
    reg_read(3'd5, "R7 masked view");
    drain();

    // R3 write-one-to-clear
    reg_write(3'd0, 32'h0000_0011);
    reg_read(3'd0, "R3 partial clear");
    drain();
    check_irq("R8 irq stays with bit2");
    reg_write(3'd0, 32'h0000_0004);
    check_irq("R3 irq drops after clear");

    // R4 software raise
    reg_write(3'd1, 32'h8000_0000);
    reg_read(3'd0, "R4 raised bit");
    reg_read(3'd1, "R4 raise reads zero");
    drain();
    check_irq("R4 raised but masked");
    reg_write(3'd3, 32'h8000_0000);
    check_irq("R8 raised and unmasked");
    reg_write(3'd2, 32'hFFFF_FFFF);
    check_irq("R5 mask-on all ones");
    reg_read(3'd6, "R5 mask full");
    drain();
    reg_write(3'd0, 32'h8000_0000);

    // R6 clear-on-read with bit 27 excluded
    reg_write(3'd4, 32'hF7FF_FFFF);
    reg_read(3'd4, "R6 clear-mode readback");
    pulse_evt(32'h0800_0003);
    reg_read(3'd0, "R6 first read");
    reg_read(3'd0, "R6 bit27 survives");
    drain();
    reg_write(3'd0, 32'h0800_0000);
    reg_read(3'd0, "R6 bit27 cleared by write");
    drain();

    // R7 masked-view read clears only unmasked clear-on-read bits
    reg_write(3'd3, 32'h0000_00F0);
    pulse_evt(32'h0000_0330);
    reg_read(3'd5, "R7 pending view");
    reg_read(3'd0, "R7 masked bits kept");
    reg_read(3'd0, "R7 all cleared");
    drain();
    check_irq("R8 idle after reads");

    // R9 event beats write-one-to-clear
    pulse_evt(32'h0000_0002);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 3'd0; cmd_wdata = 32'h2;
    hw_evt = 32'h2;
    @(negedge clk);
    cmd_valid = 1'b0; hw_evt = '0;
    reg_read(3'd0, "R9 event beats write clear");
    drain();

    // R9 event beats clear-on-read
    exp_q.push_back(32'h0); tag_q.push_back("R9 read before event");
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 3'd0; hw_evt = 32'h1;
    @(negedge clk);
    cmd_valid = 1'b0; hw_evt = '0;
    m_cause = 32'h1;
    reg_read(3'd0, "R9 event beats read clear");
    drain();

    // R10 back-pressure, write silence, spare address
    rsp_ready = 1'b0;
    reg_read(3'd6, "R10 held response data");
    #1;
    held = rsp_data;
    check(rsp_valid && !cmd_ready, "R10 stall blocks commands",
          {30'd0, rsp_valid, cmd_ready}, 32'h2);
    repeat (2) @(negedge clk);
    #1;
    check(rsp_valid && rsp_data == held, "R10 data stable", rsp_data, held);
    @(negedge clk);
    rsp_ready = 1'b1;
    drain();
    reg_write(3'd2, 32'h0000_0001);
    #1;
    check(!rsp_valid, "R10 write gives no response", {31'd0, rsp_valid}, 32'h0);
    reg_read(3'd7, "R10 spare address zero");
    drain();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule